// File: doc/BRIEF.md
# Interrupt Controller Shadow Readback

This block watches I/O writes headed for two cascaded legacy interrupt controllers and keeps its own copy of every initialization word and of the two operation words that cannot otherwise be read back. The copies are exposed through a single 8-bit read-only port. Power management or save/restore firmware reads that port twelve times to recover the full programming state of both controllers, so that it can program them again later.

On the snoop side the block sees an I/O write strobe, a 16-bit address and the write data. It tracks the initialization sequence of each controller on its own and latches each word into its slot. On the readback side, every read strobe returns the entry under an internal pointer and moves the pointer one entry on. Any write to the readback port sends the pointer back to the first entry. A few bits of some words read as fixed constants.

Top module: `pic_shadow_readback`

## Requirements
- R1: The twelve readback entries, in pointer order 0 to 11, are: controller 1 ICW1, ICW2, ICW3, ICW4, OCW2, OCW3 (entries 0 to 5), then the same six words for controller 2 (entries 6 to 11). `rd_data` always shows the entry under the pointer, without a clock delay.
- R2: A cycle with `rd_stb` high and `rd_wr` low moves the pointer to the next entry at the clock edge. From entry 11 it moves to entry 0.
- R3: A cycle with `rd_wr` high sets the pointer to entry 0, even when `rd_stb` is high in the same cycle. A read in that cycle still returns the entry under the old pointer.
- R4: After reset the pointer is at entry 0 and every shadow slot holds 00h.
- R5: An even-port write with data bit 4 set is stored as ICW1 and starts that controller's initialization sequence. The next odd-port write is stored as ICW2.
- R6: After ICW2, the next odd-port write is stored as ICW3 only if ICW1 bit 1 was 0. The odd-port write after that (or after ICW2 when no ICW3 is expected) is stored as ICW4 only if ICW1 bit 0 was 1. After the last expected word the sequence ends.
- R7: An even-port write with data bits 4 and 3 both clear is stored as OCW2. An even-port write with bit 4 clear and bit 3 set is stored as OCW3. Neither one changes the progress of an initialization sequence.
- R8: An odd-port write made while no initialization word is expected (a mask write) changes no slot. A write to any address other than the four controller ports changes no slot.
- R9: On readback, ICW4 bits [7:5] read 0, OCW2 bits [6:3] read 0, OCW3 bit 7 reads 0 and OCW3 bit 3 reads 1. All other bits read as they were written.
- R10: Controller 1 decodes at the full 16-bit addresses 0020h (even) and 0021h (odd). Controller 2 decodes at 00A0h (even) and 00A1h (odd).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_wr | input | 1 | Snooped I/O write strobe, one cycle per write |
| io_addr | input | 16 | Snooped I/O write address |
| io_wdata | input | 8 | Snooped I/O write data |
| rd_stb | input | 1 | Read of the readback port; advances the pointer |
| rd_wr | input | 1 | Write to the readback port; sets the pointer to entry 0 |
| rd_data | output | 8 | Formatted shadow entry under the pointer |

## Verification
The assertions assume that each snooped write and each readback access lasts exactly one clock cycle, and that `io_addr` and `io_wdata` are valid whenever `io_wr` is high. They also assume that strobes are never left unknown after reset. The stimulus drives every strobe for a single cycle from the falling edge and returns it low afterwards. It uses only known 16-bit addresses and writes each initialization word in an order the sequence tracker expects. Deliberately stray writes, such as mask writes and writes to unrelated or aliased addresses, are still well-formed single-cycle accesses.

// File: rtl/pic_shadow_pkg.sv
package pic_shadow_pkg;
  localparam int DATA_W        = 8;
  localparam int ADDR_W        = 16;
  localparam int NUM_CTL       = 2;
  localparam int WORDS_PER_CTL = 6;
  localparam int NUM_SLOTS     = NUM_CTL * WORDS_PER_CTL;
  localparam int PTR_W         = $clog2(NUM_SLOTS);

  // word position inside one controller's group of slots
  localparam int IDX_ICW1 = 0;
  localparam int IDX_ICW2 = 1;
  localparam int IDX_ICW3 = 2;
  localparam int IDX_ICW4 = 3;
  localparam int IDX_OCW2 = 4;
  localparam int IDX_OCW3 = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WANT_ICW2,
    SEQ_WANT_ICW3,
    SEQ_WANT_ICW4
  } init_seq_e;

  // readback formatting: force the fixed bits of each word kind
  function automatic logic [DATA_W-1:0] fmt_word(input logic [2:0] widx,
                                                 input logic [DATA_W-1:0] raw);
    logic [DATA_W-1:0] v;
    v = raw;
    case (widx)
      3'(IDX_ICW4): v = raw & 8'h1F;
      3'(IDX_OCW2): v = raw & 8'h87;
      3'(IDX_OCW3): v = (raw & 8'h7F) | 8'h08;
      default:      v = raw;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pic_snoop_decoder.sv
module pic_snoop_decoder
  import pic_shadow_pkg::*;
#(
  parameter int                 AW   = ADDR_W,
  parameter int                 DW   = DATA_W,
  parameter int                 NW   = WORDS_PER_CTL,
  parameter logic [AW-1:0]      BASE = 16'h0020
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [NW-1:0] cap_en
);
  localparam logic [AW-1:0] ODD_ADDR = BASE | {{(AW-1){1'b0}}, 1'b1};

  init_seq_e seq_q, seq_d;
  logic      single_q, single_d;
  logic      need4_q, need4_d;
  logic      hit_even, hit_odd;

  assign hit_even = io_wr && (io_addr == BASE);
  assign hit_odd  = io_wr && (io_addr == ODD_ADDR);

  always_comb begin
    seq_d    = seq_q;
    single_d = single_q;
    need4_d  = need4_q;
    cap_en   = '0;
    if (hit_even) begin
      if (io_wdata[4]) begin
        cap_en[IDX_ICW1] = 1'b1;
        seq_d            = SEQ_WANT_ICW2;
        single_d         = io_wdata[1];
        need4_d          = io_wdata[0];
      end else if (io_wdata[3]) begin
        cap_en[IDX_OCW3] = 1'b1;
      end else begin
        cap_en[IDX_OCW2] = 1'b1;
      end
    end else if (hit_odd) begin
      case (seq_q)
        SEQ_WANT_ICW2: begin
          cap_en[IDX_ICW2] = 1'b1;
          if (!single_q)    seq_d = SEQ_WANT_ICW3;
          else if (need4_q) seq_d = SEQ_WANT_ICW4;
          else              seq_d = SEQ_IDLE;
        end
        SEQ_WANT_ICW3: begin
          cap_en[IDX_ICW3] = 1'b1;
          seq_d = need4_q ? SEQ_WANT_ICW4 : SEQ_IDLE;
        end
        SEQ_WANT_ICW4: begin
          cap_en[IDX_ICW4] = 1'b1;
          seq_d = SEQ_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q    <= SEQ_IDLE;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
    end else begin
      seq_q    <= seq_d;
      single_q <= single_d;
      need4_q  <= need4_d;
    end
  end

  // R6: ICW3 only taken when ICW1 asked for cascade mode
  assert_icw3_cascade_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en[IDX_ICW3] |-> !single_q);
  // R6: ICW4 only taken when ICW1 asked for it
  assert_icw4_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en[IDX_ICW4] |-> need4_q);
  // R8: odd write outside a sequence captures nothing
  assert_mask_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_odd && seq_q == SEQ_IDLE) |-> (cap_en == '0));
  // R5: after ICW1 the sequence expects ICW2
  assert_icw1_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en[IDX_ICW1] |=> (seq_q == SEQ_WANT_ICW2));
  // R7: operation words leave the sequence untouched
  assert_ocw_keeps_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en[IDX_OCW2] || cap_en[IDX_OCW3]) |=> $stable(seq_q));
endmodule

// File: rtl/pic_shadow_bank.sv
module pic_shadow_bank
  import pic_shadow_pkg::*;
#(
  parameter int NS = NUM_SLOTS,
  parameter int NW = WORDS_PER_CTL,
  parameter int DW = DATA_W,
  parameter int PW = PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] cap_en,
  input  logic [DW-1:0] cap_data,
  input  logic [PW-1:0] rd_ptr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot_q [NS];
  logic [DW-1:0] slot_d [NS];
  logic [PW-1:0] word_idx;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      slot_d[i] = cap_en[i] ? cap_data : slot_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < NS; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign word_idx = rd_ptr % PW'(NW);
  assign rd_data  = fmt_word(word_idx[2:0], slot_q[rd_ptr]);

  // R9: forced bits of ICW4 / OCW2 / OCW3 on readback
  assert_icw4_fmt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_idx == PW'(IDX_ICW4)) |-> (rd_data[7:5] == 3'b000));
  assert_ocw2_fmt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_idx == PW'(IDX_OCW2)) |-> (rd_data[6:3] == 4'b0000));
  assert_ocw3_fmt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_idx == PW'(IDX_OCW3)) |-> (rd_data[3] && !rd_data[7]));
endmodule

// File: rtl/pic_read_seq.sv
module pic_read_seq
  import pic_shadow_pkg::*;
#(
  parameter int NS = NUM_SLOTS,
  parameter int PW = PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          rd_wr,
  output logic [PW-1:0] ptr_q
);
  localparam logic [PW-1:0] LAST = PW'(NS - 1);

  logic [PW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (rd_wr)       ptr_d = '0;
    else if (rd_stb) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R2: pointer stays inside the twelve entries and wraps
  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
  assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_wr && ptr_q == LAST) |=> (ptr_q == '0));
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !rd_wr) |=> $stable(ptr_q));
  // R3: write to the readback port restarts the order
  assert_ptr_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wr |=> (ptr_q == '0));
endmodule

// File: rtl/pic_shadow_readback.sv
module pic_shadow_readback
  import pic_shadow_pkg::*;
#(
  parameter int                 AW        = ADDR_W,
  parameter int                 DW        = DATA_W,
  parameter logic [AW-1:0]      CTL1_BASE = 16'h0020,
  parameter logic [AW-1:0]      CTL2_BASE = 16'h00A0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          rd_stb,
  input  logic          rd_wr,
  output logic [DW-1:0] rd_data
);
  localparam int NC = NUM_CTL;
  localparam int NW = WORDS_PER_CTL;
  localparam int NS = NC * NW;
  localparam int PW = $clog2(NS);

  logic          rst_meta_q, rst_sync_q;
  logic [NS-1:0] cap_all;
  logic [PW-1:0] ptr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_ctl
    localparam logic [AW-1:0] BASE_C = (c == 0) ? CTL1_BASE : CTL2_BASE;
    pic_snoop_decoder #(.AW(AW), .DW(DW), .NW(NW), .BASE(BASE_C)) u_dec (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .io_wr    (io_wr),
      .io_addr  (io_addr),
      .io_wdata (io_wdata),
      .cap_en   (cap_all[c*NW +: NW])
    );
  end

  pic_shadow_bank #(.NS(NS), .NW(NW), .DW(DW), .PW(PW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .cap_en   (cap_all),
    .cap_data (io_wdata),
    .rd_ptr   (ptr),
    .rd_data  (rd_data)
  );

  pic_read_seq #(.NS(NS), .PW(PW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .rd_stb (rd_stb),
    .rd_wr  (rd_wr),
    .ptr_q  (ptr)
  );

  // R10: a write lands in at most one slot, and only at a controller port
  assert_one_slot_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(cap_all));
  assert_decode_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cap_all != '0) |-> (io_addr[AW-1:8] == '0 &&
                         (io_addr[7:1] == CTL1_BASE[7:1] || io_addr[7:1] == CTL2_BASE[7:1])));
  // R4: slot 0 read right after reset is zero
  assert_reset_state_R4: assert property (@(posedge clk)
    (rst_sync_q && !$past(rst_sync_q)) |-> (ptr == '0 && rd_data == '0));
endmodule

// File: tb/tb_pic_shadow_readback.sv
module tb_pic_shadow_readback;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        rd_stb;
  logic        rd_wr;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] mslot [12];
  int         exp_ptr = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;  // 50 MHz

  pic_shadow_readback dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .rd_stb(rd_stb), .rd_wr(rd_wr), .rd_data(rd_data)
  );

  function automatic logic [7:0] fmt_exp(int i);
    logic [7:0] v;
    v = mslot[i];
    case (i % 6)
      3: v = v & 8'h1F;
      4: v = v & 8'h87;
      5: v = (v & 8'h7F) | 8'h08;
      default: ;
    endcase
    return v;
  endfunction

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0; io_wdata = 8'h0;
  endtask

  // driver: one read, pushes expected entry for the scoreboard
  task automatic do_read(input string tag, input bit with_restart = 1'b0);
    @(negedge clk);
    exp_q.push_back(fmt_exp(exp_ptr));
    tag_q.push_back(tag);
    rd_stb = 1'b1;
    rd_wr  = with_restart;
    exp_ptr = with_restart ? 0 : (exp_ptr + 1) % 12;
    @(negedge clk);
    rd_stb = 1'b0; rd_wr = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    rd_wr = 1'b1;
    @(negedge clk);
    rd_wr = 1'b0;
    exp_ptr = 0;
  endtask

  task automatic read_all(input string tag);
    restart();
    for (int i = 0; i < 12; i++) do_read(tag);
  endtask

  // R5, R6: full init sequence of one controller, model updated from the rules
  task automatic init_ctl(input int c, input logic [7:0] w1, input logic [7:0] w2,
                          input logic [7:0] w3, input logic [7:0] w4);
    logic [15:0] base;
    base = (c == 0) ? 16'h0020 : 16'h00A0;
    io_write(base, w1);       mslot[c*6 + 0] = w1;
    io_write(base | 16'h1, w2); mslot[c*6 + 1] = w2;
    if (!w1[1]) begin io_write(base | 16'h1, w3); mslot[c*6 + 2] = w3; end
    if (w1[0])  begin io_write(base | 16'h1, w4); mslot[c*6 + 3] = w4; end
  endtask

  // monitor: compares rd_data halfway before the edge that acts on the read
  always begin
    @(negedge clk);
    #5;
    if (rd_stb) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s rd_data=%02h expected=%02h", t, rd_data, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 4000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    io_wr = 0; io_addr = 0; io_wdata = 0; rd_stb = 0; rd_wr = 0;
    for (int i = 0; i < 12; i++) mslot[i] = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4: pointer at entry 0 and all slots zero, read without restart
    for (int i = 0; i < 12; i++) do_read("R4 reset state");

    // R1 R5 R6 R9 R10: both controllers programmed, full cascade with ICW4
    init_ctl(0, 8'h11, 8'h08, 8'h04, 8'hFF);
    init_ctl(1, 8'h19, 8'h70, 8'h02, 8'hE3);
    // R7: operation words
    io_write(16'h0020, 8'hE7); mslot[4]  = 8'hE7;
    io_write(16'h0020, 8'h8A); mslot[5]  = 8'h8A;
    io_write(16'h00A0, 8'h63); mslot[10] = 8'h63;
    io_write(16'h00A0, 8'h6B); mslot[11] = 8'h6B;
    read_all("R1 R9 order and formatting");

    // R3: restart alone and restart in the same cycle as a read
    restart();
    do_read("R3 after restart");
    do_read("R3 second entry");
    do_read("R3 third entry");
    do_read("R3 read with restart", 1'b1);
    do_read("R3 first entry after restart");

    // R2: wrap from entry 11 to entry 0
    read_all("R2 walk");
    do_read("R2 wrap to entry 0");

    // R6 R8: single mode without ICW4, then a mask write that must not land
    init_ctl(0, 8'h12, 8'h40, 8'h00, 8'h00);
    io_write(16'h0021, 8'h55);
    read_all("R6 R8 single mode and mask write");

    // R6: single mode with ICW4, ICW3 of controller 2 kept
    init_ctl(1, 8'h13, 8'h28, 8'h00, 8'h01);
    read_all("R6 single mode with ICW4");

    // R8 R10: writes to unrelated and aliased addresses
    io_write(16'h0120, 8'h1F);
    io_write(16'h0121, 8'hAA);
    io_write(16'h00A2, 8'h1B);
    io_write(16'h0024, 8'h00);
    io_write(16'h00A1, 8'h99);
    read_all("R8 R10 ignored writes");

    // R7: operation word in the middle of an init sequence
    io_write(16'h0020, 8'h11); mslot[0] = 8'h11;
    io_write(16'h0021, 8'h10); mslot[1] = 8'h10;
    io_write(16'h0020, 8'hC0); mslot[4] = 8'hC0;
    io_write(16'h0021, 8'h06); mslot[2] = 8'h06;
    io_write(16'h0021, 8'h01); mslot[3] = 8'h01;
    read_all("R7 OCW inside sequence");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R1 reads pending=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule